// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer datapath of one channel of an ISA-style DMA controller. It keeps a 16-bit current address, a 16-bit current count and an 8-bit page value, and from them it forms the 24-bit physical bus address for every transfer cycle. Each accepted transfer pulse steps the address by one, either up or down, and decrements the count. The count is held as the number of transfers minus one, so terminal count is reached on the transfer made while the count is zero, when it wraps to all ones. At that point the channel either stops or, when auto-reload is enabled, restores its address and count from base copies taken at load time.

A parameter chooses a byte channel or a word channel. A byte channel places the page above the 16-bit address, which gives 64K-byte pages. A word channel treats the address as a word address: it shifts it up by one bit, forces physical bit 0 low and drops the low page bit, which gives 128K-byte pages. The 16-bit address wraps inside its page and never carries into the page. The residue output reports the transfers still pending (count plus one, modulo 2^16), doubled to bytes on a word channel.

A small state machine gates stepping. Its states are EMPTY (after reset, nothing loaded), ACTIVE (steps accepted) and DONE (terminal count reached without auto-reload). Its transitions are: EMPTY to ACTIVE on a load of address or count; ACTIVE to ACTIVE on any load or on terminal count with auto-reload; ACTIVE to DONE on terminal count without auto-reload; DONE to ACTIVE on a load of address or count. A page load causes no transition.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the physical address is 0, the residue is 0 and terminal count is low; a step pulse in the EMPTY state changes none of these.
- R2: Writing the count with value V makes the residue (V+1) mod 2^16 on a byte channel in the next cycle, so V = 0xFFFF reads as residue 0.
- R3: Each accepted step decrements the count by one and moves the address by +1 when the direction input is 0 and by -1 when it is 1, wrapping modulo 2^16.
- R4: The terminal-count output is high for exactly the cycle following the accepted step that was made while the count was 0x0000.
- R5: Without auto-reload, after terminal count the address and count stay unchanged under further steps until address or count is written again.
- R6: With auto-reload high, terminal count restores the current address and count to the values last written, and stepping continues.
- R7: Writing the page changes neither the current address nor the count (the residue is unchanged).
- R8: On a byte channel the physical address is {page[7:0], address[15:0]}; an address wrap from 0xFFFF to 0x0000 leaves bits 23:16 unchanged.
- R9: On a word channel the physical address is {page[7:1], address[15:0], 1'b0}; page bit 0 has no effect.
- R10: On a word channel the residue is 2 x ((count+1) mod 2^16), a 17-bit value.
- R11: An address or count write coincident with a step takes effect and the step is dropped.
- R12: A count of 0xFFFF yields 65536 accepted steps, with terminal count only on the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load base and current address from wr_data |
| cnt_wr | input | 1 | Load base and current count from wr_data |
| page_wr | input | 1 | Load page from page_data |
| wr_data | input | ADDR_W | Address or count value to load |
| page_data | input | PAGE_W | Page value to load |
| autoinit | input | 1 | Reload from base copies on terminal count |
| addr_down | input | 1 | 1: address steps down, 0: steps up |
| step | input | 1 | One transfer completed |
| phys_addr | output | ADDR_W+PAGE_W | Physical bus address |
| tc | output | 1 | Terminal-count pulse |
| residue | output | ADDR_W+1 | Transfers pending, in bytes |

## Verification
The bench builds the block twice side by side with the default 16-bit address and 8-bit page: once as a byte channel and once as a word channel, both driven by the same stimulus. This puts the two address layouts, the ignored page bit and the doubled residue in the same scenarios, so each mapping is compared against the other's expected value cycle by cycle. The default widths keep a full 65536-transfer run short enough to exercise the largest count end to end.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        CH_EMPTY  = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_DONE   = 2'd2
    } ch_state_e;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_any,
    input  logic      step,
    input  logic      cnt_zero,
    input  logic      autoinit,
    output logic      accept,
    output logic      reload,
    output logic      tc,
    output ch_state_e state
);

    ch_state_e state_nx;
    logic      tc_hit;

    // steps are honoured only while running and never alongside a load
    assign accept = (state == CH_ACTIVE) && step && !load_any;
    assign tc_hit = accept && cnt_zero;
    assign reload = tc_hit && autoinit;

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_EMPTY: begin
                if (load_any) state_nx = CH_ACTIVE;
            end
            CH_ACTIVE: begin
                if (load_any)                 state_nx = CH_ACTIVE;
                else if (tc_hit && !autoinit) state_nx = CH_DONE;
            end
            CH_DONE: begin
                if (load_any) state_nx = CH_ACTIVE;
            end
            default: state_nx = CH_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_EMPTY;
        else        state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) tc <= 1'b0;
        else        tc <= tc_hit;
    end

    // R4: terminal count only follows an accepted step at count zero
    a_r4_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_any && state == CH_ACTIVE && cnt_zero) |=> tc);

    // R5: a finished channel ignores steps until reloaded
    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && !load_any) |=> (state == CH_DONE && !tc));

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    input  logic              page_wr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] page_data,
    input  logic              addr_down,
    input  logic              accept,
    input  logic              reload,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic [PAGE_W-1:0] page_q,
    output logic              cnt_zero
);

    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] base_cnt;

    assign cnt_zero = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_wr) begin
            base_addr <= wr_data;
            cur_addr  <= wr_data;
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (accept) begin
            cur_addr  <= addr_down ? (cur_addr - ONE) : (cur_addr + ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= ALL_ONES;
            cur_cnt  <= ALL_ONES;
        end else if (cnt_wr) begin
            base_cnt <= wr_data;
            cur_cnt  <= wr_data;
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (accept) begin
            cur_cnt  <= cur_cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (page_wr) page_q <= page_data;
    end

    // R2: a count write lands unchanged
    a_r2_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cur_cnt == $past(wr_data)));

    // R3: an ordinary step takes exactly one off the count
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !reload) |=> (cur_cnt == $past(cur_cnt) - ONE));

    // R6: auto-reload restores the base copies
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cur_addr == $past(base_addr) && cur_cnt == $past(base_cnt)));

    // R7: a lone page write leaves address and count alone
    a_r7_page_only: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && !addr_wr && !cnt_wr && !accept) |=> ($stable(cur_addr) && $stable(cur_cnt)));

endmodule

// File: rtl/dma_seq_map.sv
module dma_seq_map #(
    parameter bit WORD_MODE = 1'b0,
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8
) (
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [ADDR_W-1:0]        cur_cnt,
    input  logic [PAGE_W-1:0]        page_q,
    output logic [ADDR_W+PAGE_W-1:0] phys_addr,
    output logic [ADDR_W:0]          residue
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] pending;

    // wraps naturally: all ones reads as zero pending
    assign pending = cur_cnt + ONE;

    generate
        if (WORD_MODE) begin : g_word
            logic page_lsb_unused;
            assign page_lsb_unused = page_q[0];
            assign phys_addr = {page_q[PAGE_W-1:1], cur_addr, 1'b0};
            assign residue   = {pending, 1'b0};
        end else begin : g_byte
            assign phys_addr = {page_q, cur_addr};
            assign residue   = {1'b0, pending};
        end
    endgenerate

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0,
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_wr,
    input  logic                     cnt_wr,
    input  logic                     page_wr,
    input  logic [ADDR_W-1:0]        wr_data,
    input  logic [PAGE_W-1:0]        page_data,
    input  logic                     autoinit,
    input  logic                     addr_down,
    input  logic                     step,
    output logic [ADDR_W+PAGE_W-1:0] phys_addr,
    output logic                     tc,
    output logic [ADDR_W:0]          residue
);

    logic              load_any;
    logic              accept;
    logic              reload;
    logic              cnt_zero;
    ch_state_e         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] cur_cnt;
    logic [PAGE_W-1:0] page_q;

    assign load_any = addr_wr | cnt_wr;

    dma_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_any (load_any),
        .step     (step),
        .cnt_zero (cnt_zero),
        .autoinit (autoinit),
        .accept   (accept),
        .reload   (reload),
        .tc       (tc),
        .state    (state)
    );

    dma_seq_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (addr_wr),
        .cnt_wr    (cnt_wr),
        .page_wr   (page_wr),
        .wr_data   (wr_data),
        .page_data (page_data),
        .addr_down (addr_down),
        .accept    (accept),
        .reload    (reload),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .page_q    (page_q),
        .cnt_zero  (cnt_zero)
    );

    dma_seq_map #(.WORD_MODE(WORD_MODE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .page_q    (page_q),
        .phys_addr (phys_addr),
        .residue   (residue)
    );

    // R5: in DONE a step without a load moves nothing
    a_r5_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && step && !load_any) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    // R11: a load beats a coincident step
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && step) |=> (cur_addr == $past(wr_data)));

    // R8: address wrap leaves the page bits of the bus address alone
    a_r8_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_wr) |=> (phys_addr[ADDR_W+PAGE_W-1:ADDR_W+1] == $past(phys_addr[ADDR_W+PAGE_W-1:ADDR_W+1])));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_wr = 1'b0, cnt_wr = 1'b0, page_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  page_data = '0;
    logic        autoinit = 1'b0, addr_down = 1'b0, step = 1'b0;

    logic [23:0] phys_b, phys_w;
    logic        tc_b, tc_w;
    logic [16:0] res_b, res_w;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_chan_seq #(.WORD_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .cnt_wr(cnt_wr),
        .page_wr(page_wr), .wr_data(wr_data), .page_data(page_data),
        .autoinit(autoinit), .addr_down(addr_down), .step(step),
        .phys_addr(phys_b), .tc(tc_b), .residue(res_b)
    );

    dma_chan_seq #(.WORD_MODE(1'b1)) uut_w (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .cnt_wr(cnt_wr),
        .page_wr(page_wr), .wr_data(wr_data), .page_data(page_data),
        .autoinit(autoinit), .addr_down(addr_down), .step(step),
        .phys_addr(phys_w), .tc(tc_w), .residue(res_w)
    );

    function automatic logic [23:0] wmap(logic [7:0] pg, logic [15:0] a);
        return {pg[7:1], a, 1'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // both builds at once: byte address, word address, byte residue
    task automatic check_pos(string req, logic [7:0] pg, logic [15:0] a, logic [15:0] pend);
        check(req, {8'h0, phys_b}, {8'h0, pg, a});
        check(req, {8'h0, phys_w}, {8'h0, wmap(pg, a)});
        check(req, {15'h0, res_b}, {16'h0, pend});
        check(req, {15'h0, res_w}, {15'h0, pend, 1'b0});
    endtask

    task automatic do_step();
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
    endtask

    task automatic load_addr(logic [15:0] v);
        @(negedge clk) begin addr_wr = 1'b1; wr_data = v; end
        @(negedge clk) addr_wr = 1'b0;
    endtask

    task automatic load_cnt(logic [15:0] v);
        @(negedge clk) begin cnt_wr = 1'b1; wr_data = v; end
        @(negedge clk) cnt_wr = 1'b0;
    endtask

    task automatic load_page(logic [7:0] v);
        @(negedge clk) begin page_wr = 1'b1; page_data = v; end
        @(negedge clk) page_wr = 1'b0;
    endtask

    task automatic t_reset();
        check_pos("R1 reset", 8'h00, 16'h0000, 16'h0000);
        check("R1 reset tc", {31'h0, tc_b | tc_w}, 32'h0);
        do_step();
        check_pos("R1 step ignored when empty", 8'h00, 16'h0000, 16'h0000);
        check("R1 no tc when empty", {31'h0, tc_b | tc_w}, 32'h0);
    endtask

    task automatic t_up_and_wrap();
        load_page(8'h13);
        load_addr(16'hFFFE);
        load_cnt(16'h0002);
        check_pos("R2 R10 count load", 8'h13, 16'hFFFE, 16'h0003);
        do_step();
        check_pos("R3 step up", 8'h13, 16'hFFFF, 16'h0002);
        check("R4 no early tc", {31'h0, tc_b}, 32'h0);
        do_step();
        check_pos("R8 R9 wrap without carry", 8'h13, 16'h0000, 16'h0001);
        do_step();
        check("R4 tc byte", {31'h0, tc_b}, 32'h1);
        check("R4 tc word", {31'h0, tc_w}, 32'h1);
        check_pos("R2 residue zero at end", 8'h13, 16'h0001, 16'h0000);
        @(negedge clk);
        check("R4 tc one cycle", {31'h0, tc_b | tc_w}, 32'h0);
        do_step();
        do_step();
        check_pos("R5 steps ignored after tc", 8'h13, 16'h0001, 16'h0000);
        check("R5 no tc after done", {31'h0, tc_b | tc_w}, 32'h0);
    endtask

    task automatic t_down();
        addr_down = 1'b1;
        load_addr(16'h0001);
        load_cnt(16'h0001);
        do_step();
        check_pos("R3 step down", 8'h13, 16'h0000, 16'h0001);
        do_step();
        check_pos("R3 down wrap", 8'h13, 16'hFFFF, 16'h0000);
        check("R4 tc down", {31'h0, tc_b}, 32'h1);
        addr_down = 1'b0;
    endtask

    task automatic t_autoinit();
        autoinit = 1'b1;
        load_addr(16'h0100);
        load_cnt(16'h0001);
        do_step();
        check_pos("R6 first step", 8'h13, 16'h0101, 16'h0001);
        do_step();
        check("R6 tc", {31'h0, tc_b}, 32'h1);
        check_pos("R6 reloaded", 8'h13, 16'h0100, 16'h0002);
        do_step();
        check_pos("R6 keeps running", 8'h13, 16'h0101, 16'h0001);
        autoinit = 1'b0;
    endtask

    task automatic t_page_and_prio();
        load_page(8'h34);
        load_addr(16'h4000);
        load_cnt(16'h0005);
        do_step();
        check_pos("R3 before page", 8'h34, 16'h4001, 16'h0005);
        load_page(8'h35);
        check_pos("R7 R9 page write only", 8'h35, 16'h4001, 16'h0005);
        check("R9 page bit0 ignored", {8'h0, phys_w}, {8'h0, wmap(8'h34, 16'h4001)});
        @(negedge clk) begin step = 1'b1; cnt_wr = 1'b1; wr_data = 16'h0009; end
        @(negedge clk) begin step = 1'b0; cnt_wr = 1'b0; end
        check_pos("R11 load beats step", 8'h35, 16'h4001, 16'h000A);
    endtask

    task automatic t_full_count();
        int early = 0;
        load_addr(16'h0000);
        load_cnt(16'hFFFF);
        check_pos("R12 R2 max count residue", 8'h35, 16'h0000, 16'h0000);
        @(negedge clk) step = 1'b1;
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            if (tc_b) early++;
        end
        check("R12 no early tc", early, 0);
        check_pos("R12 before last", 8'h35, 16'hFFFF, 16'h0001);
        step = 1'b0;
        @(negedge clk);
        check_pos("R12 after last", 8'h35, 16'hFFFF, 16'h0001);
        check("R12 hold", {31'h0, tc_b}, 32'h0);
        do_step();
        check("R12 tc on last", {31'h0, tc_b & tc_w}, 32'h1);
        check_pos("R12 final", 8'h35, 16'h0000, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_and_wrap();
        t_down();
        t_autoinit();
        t_page_and_prio();
        t_full_count();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule